// File: doc/BRIEF.md
# Quad-Issue Group Resource Arbiter

This block sits after instruction decode. Each cycle it receives up to four decoded instructions in program order, oldest in slot 0. Each instruction carries a class code. The block decides how long a prefix of that group can issue together without oversubscribing the shared execution units. The units are:

- two symmetric integer units
- one memory/special pipe
- one branch unit
- one FP add unit
- one FP multiply unit

It returns a per-slot grant vector and the number of granted instructions. Only structural hazards are modelled. Register dependences, operand fetch and execution are left to other blocks.

Some instructions hold resources beyond their own cycle, so the arbiter carries that occupancy from one cycle to the next:

- **Long integer operations.** An integer multiply or divide forces a run of following cycles in which at most one instruction issues.
- **Long FP operations.** FP divides and square roots keep the unpipelined FP multiply unit busy for a fixed number of further cycles.

Each kind of occupancy is held in a down-counter. Grants are combinational from the current inputs and the counter state, so the issue decision is made in the same cycle that the instructions are presented.

Top module: `ig_issue_arbiter`

## Requirements
- R1: Grants form an in-order prefix. A slot is granted only if it is valid and every older slot was granted. An invalid slot or a refused slot blocks all younger slots in that cycle. `issue_cnt_o` equals the number of set bits in `grant_o`.
- R2: Class code 0 (integer ALU/shift/compare) needs an integer unit. At most `N_INT_UNITS` (2) such instructions issue in one cycle.
- R3: Only one instruction per cycle may use the memory/special pipe. This covers codes 1 (load), 2 (store), 3 (integer multiply), 4 (integer divide), 6 (call/jump), 7 (integer conditional move) and 13 (FP register-conditional move).
- R4: Only one instruction per cycle may use the branch unit. This covers codes 5 (branch), 6, 7 and 12 (FP condition-code conditional move).
- R5: Only one instruction per cycle may use the FP add unit: codes 9 (FP move), 10 (FP add/sub), 11 (FP compare), 12 and 13. Only one instruction per cycle may use the FP multiply unit: codes 14 (FP multiply) and 15 to 18 (long FP operations).
- R6: Code 8 (serializing: multi-op, window flush, cache flush, trap) issues only from slot 0, and nothing issues with it.
- R7: An integer multiply or divide (codes 3 and 4) may issue after older instructions, but it ends the group. No younger slot is granted in that cycle.
- R8: After an integer multiply issues, the next `IMUL_SOLO_CYC` (4) cycles grant at most slot 0. After an integer divide, the next `IDIV_SOLO_CYC` (69) cycles do the same. If a new window starts while one is still running, the longer remaining window wins.
- R9: While the FP multiply unit is locked, codes 14 to 18 are refused, and other classes are unaffected. The lock lasts for the cycles after issue of:
  - code 15 (single divide): 14 cycles
  - code 16 (single sqrt): 17 cycles
  - code 17 (double divide): 17 cycles
  - code 18 (double sqrt): 26 cycles
- R10: Unassigned class codes (19 to 31) are treated as serializing, with the same rules as code 8.
- R11: While `rst_ni` is low, all grants are 0 and all occupancy is cleared. The first cycle after reset carries no single-issue or FP lock restriction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | NUM_SLOTS | Per-slot instruction valid, slot 0 oldest |
| class_i | input | NUM_SLOTS*5 | Per-slot class code, slot s at bits [5s+4:5s] |
| grant_o | output | NUM_SLOTS | Per-slot issue grant |
| issue_cnt_o | output | $clog2(NUM_SLOTS+1) | Number of instructions issued this cycle |

## Verification
The bench builds the arbiter with its default parameters: four slots, two integer units, and the full 4-, 69-, 14-, 17- and 26-cycle occupancy lengths. At a short clock period the whole 69-cycle divide window, an overlapping multiply inside it, and every FP lock length are crossed end to end, so an off-by-one at either end of any window is visible. Random class mixes that include unassigned codes reach combinations where several units are contended in the same group while a lock is active.

// File: rtl/ig_pkg.sv
package ig_pkg;

  localparam int CLS_W = 5;

  typedef enum logic [CLS_W-1:0] {
    C_IALU     = 5'd0,
    C_LOAD     = 5'd1,
    C_STORE    = 5'd2,
    C_IMUL     = 5'd3,
    C_IDIV     = 5'd4,
    C_BRANCH   = 5'd5,
    C_CALL     = 5'd6,
    C_ICMOV    = 5'd7,
    C_SOLO     = 5'd8,
    C_FMOV     = 5'd9,
    C_FADD     = 5'd10,
    C_FCMP     = 5'd11,
    C_FCMOV_CC = 5'd12,
    C_FCMOV_R  = 5'd13,
    C_FMUL     = 5'd14,
    C_FDIVS    = 5'd15,
    C_FSQRTS   = 5'd16,
    C_FDIVD    = 5'd17,
    C_FSQRTD   = 5'd18
  } ig_class_e;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_MUL,
    WIN_DIV
  } win_kind_e;

  typedef enum logic [2:0] {
    FPL_NONE,
    FPL_DIVS,
    FPL_SQRTS,
    FPL_DIVD,
    FPL_SQRTD
  } fpl_kind_e;

  typedef struct packed {
    logic      use_int;
    logic      use_mem;
    logic      use_br;
    logic      use_fpa;
    logic      use_fpm;
    logic      solo;
    logic      ends_group;
    win_kind_e win;
    fpl_kind_e fpl;
  } ig_req_t;

endpackage

// File: rtl/ig_class_decode.sv
module ig_class_decode
  import ig_pkg::*;
(
  input  logic [CLS_W-1:0] class_i,
  output ig_req_t          req_o
);

  always_comb begin
    req_o = '0;
    case (class_i)
      C_IALU:  req_o.use_int = 1'b1;

      C_LOAD, C_STORE: req_o.use_mem = 1'b1;

      C_IMUL: begin
        req_o.use_mem    = 1'b1;
        req_o.ends_group = 1'b1;
        req_o.win        = WIN_MUL;
      end

      C_IDIV: begin
        req_o.use_mem    = 1'b1;
        req_o.ends_group = 1'b1;
        req_o.win        = WIN_DIV;
      end

      C_BRANCH: req_o.use_br = 1'b1;

      C_CALL, C_ICMOV: begin
        req_o.use_br  = 1'b1;
        req_o.use_mem = 1'b1;
      end

      C_FMOV, C_FADD, C_FCMP: req_o.use_fpa = 1'b1;

      C_FCMOV_CC: begin
        req_o.use_fpa = 1'b1;
        req_o.use_br  = 1'b1;
      end

      C_FCMOV_R: begin
        req_o.use_fpa = 1'b1;
        req_o.use_mem = 1'b1;
      end

      C_FMUL: req_o.use_fpm = 1'b1;

      C_FDIVS: begin
        req_o.use_fpm = 1'b1;
        req_o.fpl     = FPL_DIVS;
      end

      C_FSQRTS: begin
        req_o.use_fpm = 1'b1;
        req_o.fpl     = FPL_SQRTS;
      end

      C_FDIVD: begin
        req_o.use_fpm = 1'b1;
        req_o.fpl     = FPL_DIVD;
      end

      C_FSQRTD: begin
        req_o.use_fpm = 1'b1;
        req_o.fpl     = FPL_SQRTD;
      end

      // serializing class and every unassigned code
      default: begin
        req_o.solo       = 1'b1;
        req_o.ends_group = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ig_group_select.sv
module ig_group_select
  import ig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int N_INT     = 2
) (
  input  logic [NUM_SLOTS-1:0] valid_i,
  input  ig_req_t [NUM_SLOTS-1:0] req_i,
  input  logic                 win_busy_i,
  input  logic                 fpm_busy_i,
  output logic [NUM_SLOTS-1:0] grant_o
);

  localparam int CW = $clog2(NUM_SLOTS + 1);

  logic [CW-1:0] int_used;
  logic mem_used, br_used, fpa_used, fpm_used;
  logic stop, fit;

  always_comb begin
    int_used = '0;
    mem_used = 1'b0;
    br_used  = 1'b0;
    fpa_used = 1'b0;
    fpm_used = 1'b0;
    stop     = 1'b0;
    fit      = 1'b0;
    grant_o  = '0;

    for (int i = 0; i < NUM_SLOTS; i++) begin
      fit = valid_i[i] && !stop;
      if (req_i[i].use_int && (int_used >= CW'(N_INT))) fit = 1'b0;
      if (req_i[i].use_mem && mem_used)                 fit = 1'b0;
      if (req_i[i].use_br  && br_used)                  fit = 1'b0;
      if (req_i[i].use_fpa && fpa_used)                 fit = 1'b0;
      if (req_i[i].use_fpm && (fpm_used || fpm_busy_i)) fit = 1'b0;
      // solo class and single-issue window confine the group to slot 0
      if ((req_i[i].solo || win_busy_i) && (i != 0))    fit = 1'b0;

      grant_o[i] = fit;

      if (fit) begin
        int_used = int_used + CW'(req_i[i].use_int);
        mem_used = mem_used | req_i[i].use_mem;
        br_used  = br_used  | req_i[i].use_br;
        fpa_used = fpa_used | req_i[i].use_fpa;
        fpm_used = fpm_used | req_i[i].use_fpm;
      end

      stop = !fit || req_i[i].ends_group || win_busy_i;
    end
  end

endmodule

// File: rtl/ig_occupancy.sv
module ig_occupancy #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);

  logic [W-1:0] cnt_q, dec, nxt;

  always_comb begin
    dec = (cnt_q != '0) ? cnt_q - W'(1) : '0;
    // a new claim never shortens a window already running
    nxt = (load_val_i > dec) ? load_val_i : dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ig_issue_arbiter.sv
module ig_issue_arbiter
  import ig_pkg::*;
#(
  parameter int NUM_SLOTS     = 4,
  parameter int N_INT_UNITS   = 2,
  parameter int IMUL_SOLO_CYC = 4,
  parameter int IDIV_SOLO_CYC = 69,
  parameter int FDIVS_LOCK    = 14,
  parameter int FSQRTS_LOCK   = 17,
  parameter int FDIVD_LOCK    = 17,
  parameter int FSQRTD_LOCK   = 26
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SLOTS-1:0]             valid_i,
  input  logic [NUM_SLOTS*CLS_W-1:0]       class_i,
  output logic [NUM_SLOTS-1:0]             grant_o,
  output logic [$clog2(NUM_SLOTS+1)-1:0]   issue_cnt_o
);

  localparam int CNT_W   = $clog2(NUM_SLOTS + 1);
  localparam int WIN_MAX = (IMUL_SOLO_CYC > IDIV_SOLO_CYC) ? IMUL_SOLO_CYC : IDIV_SOLO_CYC;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int FPL_M0  = (FDIVS_LOCK > FSQRTS_LOCK) ? FDIVS_LOCK : FSQRTS_LOCK;
  localparam int FPL_M1  = (FDIVD_LOCK > FSQRTD_LOCK) ? FDIVD_LOCK : FSQRTD_LOCK;
  localparam int FPL_MAX = (FPL_M0 > FPL_M1) ? FPL_M0 : FPL_M1;
  localparam int FPL_W   = $clog2(FPL_MAX + 1);

  ig_req_t [NUM_SLOTS-1:0] req;
  logic [NUM_SLOTS-1:0]    sel_grant;
  logic                    win_busy, fpm_busy;
  logic [WIN_W-1:0]        win_load, win_v;
  logic [FPL_W-1:0]        fpl_load, fpl_v;
  logic [CNT_W-1:0]        cnt;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
    ig_class_decode u_dec (
      .class_i (class_i[s*CLS_W +: CLS_W]),
      .req_o   (req[s])
    );
  end

  ig_group_select #(
    .NUM_SLOTS (NUM_SLOTS),
    .N_INT     (N_INT_UNITS)
  ) u_sel (
    .valid_i    (valid_i),
    .req_i      (req),
    .win_busy_i (win_busy),
    .fpm_busy_i (fpm_busy),
    .grant_o    (sel_grant)
  );

  assign grant_o = rst_ni ? sel_grant : '0;

  // occupancy claimed by the granted instructions of this cycle
  always_comb begin
    win_load = '0;
    fpl_load = '0;
    cnt      = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      case (req[s].win)
        WIN_MUL: win_v = WIN_W'(IMUL_SOLO_CYC);
        WIN_DIV: win_v = WIN_W'(IDIV_SOLO_CYC);
        default: win_v = '0;
      endcase
      case (req[s].fpl)
        FPL_DIVS:  fpl_v = FPL_W'(FDIVS_LOCK);
        FPL_SQRTS: fpl_v = FPL_W'(FSQRTS_LOCK);
        FPL_DIVD:  fpl_v = FPL_W'(FDIVD_LOCK);
        FPL_SQRTD: fpl_v = FPL_W'(FSQRTD_LOCK);
        default:   fpl_v = '0;
      endcase
      if (grant_o[s]) begin
        if (win_v > win_load) win_load = win_v;
        if (fpl_v > fpl_load) fpl_load = fpl_v;
        cnt = cnt + CNT_W'(1);
      end
    end
  end

  assign issue_cnt_o = cnt;

  ig_occupancy #(.W(WIN_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_val_i (win_load),
    .busy_o     (win_busy)
  );

  ig_occupancy #(.W(FPL_W)) u_fpm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_val_i (fpl_load),
    .busy_o     (fpm_busy)
  );

endmodule

// File: rtl/ig_issue_arbiter_chk.sv
module ig_issue_arbiter_chk #(
  parameter int NUM_SLOTS     = 4,
  parameter int N_INT_UNITS   = 2,
  parameter int IMUL_SOLO_CYC = 4,
  parameter int IDIV_SOLO_CYC = 69,
  parameter int FDIVS_LOCK    = 14,
  parameter int FSQRTS_LOCK   = 17,
  parameter int FDIVD_LOCK    = 17,
  parameter int FSQRTD_LOCK   = 26
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_SLOTS-1:0]           valid_i,
  input logic [NUM_SLOTS*5-1:0]         class_i,
  input logic [NUM_SLOTS-1:0]           grant_o,
  input logic [$clog2(NUM_SLOTS+1)-1:0] issue_cnt_o
);

  logic [NUM_SLOTS:0]   g_plus;
  logic [NUM_SLOTS-1:0] mem_g, solo_g, fpm_g, int_g;
  int                   win_ld, fpl_ld;
  int                   chk_win, chk_fpl;

  always_comb begin
    g_plus = {1'b0, grant_o} + 1'b1;
    win_ld = 0;
    fpl_ld = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      int c;
      c = int'(class_i[s*5 +: 5]);
      int_g[s]  = grant_o[s] && (c == 0);
      mem_g[s]  = grant_o[s] && (c inside {1, 2, 3, 4, 6, 7, 13});
      solo_g[s] = grant_o[s] && ((c == 8) || (c > 18));
      fpm_g[s]  = grant_o[s] && (c >= 14) && (c <= 18);
      if (grant_o[s]) begin
        if (c == 3 && IMUL_SOLO_CYC > win_ld) win_ld = IMUL_SOLO_CYC;
        if (c == 4 && IDIV_SOLO_CYC > win_ld) win_ld = IDIV_SOLO_CYC;
        if (c == 15) fpl_ld = FDIVS_LOCK;
        if (c == 16) fpl_ld = FSQRTS_LOCK;
        if (c == 17) fpl_ld = FDIVD_LOCK;
        if (c == 18) fpl_ld = FSQRTD_LOCK;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_win <= 0;
      chk_fpl <= 0;
    end else begin
      chk_win <= (win_ld > chk_win - 1) ? win_ld : ((chk_win > 0) ? chk_win - 1 : 0);
      chk_fpl <= (fpl_ld > chk_fpl - 1) ? fpl_ld : ((chk_fpl > 0) ? chk_fpl - 1 : 0);
    end
  end

  AST_GRANT_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(g_plus) == 1); // R1
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~valid_i) == '0); // R1
  AST_COUNT_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(issue_cnt_o) == $countones(grant_o)); // R1
  AST_INT_UNITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(int_g) <= N_INT_UNITS); // R2
  AST_MEM_PIPE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_g)); // R3
  AST_SOLO_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_g != '0) |-> (grant_o == {{(NUM_SLOTS-1){1'b0}}, 1'b1})); // R6
  AST_SINGLE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_win != 0) |-> (issue_cnt_o <= 1)); // R8
  AST_FPM_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_fpl != 0) |-> (fpm_g == '0)); // R9

endmodule

bind ig_issue_arbiter ig_issue_arbiter_chk #(
  .NUM_SLOTS     (NUM_SLOTS),
  .N_INT_UNITS   (N_INT_UNITS),
  .IMUL_SOLO_CYC (IMUL_SOLO_CYC),
  .IDIV_SOLO_CYC (IDIV_SOLO_CYC),
  .FDIVS_LOCK    (FDIVS_LOCK),
  .FSQRTS_LOCK   (FSQRTS_LOCK),
  .FDIVD_LOCK    (FDIVD_LOCK),
  .FSQRTD_LOCK   (FSQRTD_LOCK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .class_i     (class_i),
  .grant_o     (grant_o),
  .issue_cnt_o (issue_cnt_o)
);

// File: tb/tb_ig_issue_arbiter.sv
`timescale 1ns/1ps
module tb_ig_issue_arbiter;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  valid_i = '0;
  logic [19:0] class_i = '0;
  logic [3:0]  grant_o;
  logic [2:0]  issue_cnt_o;

  int nvec = 0, nfail = 0;
  int m_win = 0, m_fpl = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ig_issue_arbiter dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .class_i(class_i), .grant_o(grant_o), .issue_cnt_o(issue_cnt_o)
  );

  // behavioural reference: returns grants, count and new occupancy claims
  function automatic void model(input logic [3:0] v, input int c0, c1, c2, c3,
                                output logic [3:0] g, output int cnt,
                                output int wl, output int fl);
    int c[4];
    int iu;
    bit mu, bu, au, pu, stop;
    c = '{c0, c1, c2, c3};
    iu = 0; mu = 0; bu = 0; au = 0; pu = 0; stop = 0;
    g = '0; cnt = 0; wl = 0; fl = 0;
    for (int i = 0; i < 4; i++) begin
      bit ni, nm, nb, na, np, solo, brk, ok;
      int w, f;
      ni = 0; nm = 0; nb = 0; na = 0; np = 0; solo = 0; brk = 0; w = 0; f = 0;
      case (c[i])
        0: ni = 1;
        1, 2: nm = 1;
        3: begin nm = 1; brk = 1; w = 4; end
        4: begin nm = 1; brk = 1; w = 69; end
        5: nb = 1;
        6, 7: begin nb = 1; nm = 1; end
        9, 10, 11: na = 1;
        12: begin na = 1; nb = 1; end
        13: begin na = 1; nm = 1; end
        14: np = 1;
        15: begin np = 1; f = 14; end
        16: begin np = 1; f = 17; end
        17: begin np = 1; f = 17; end
        18: begin np = 1; f = 26; end
        default: begin solo = 1; brk = 1; end
      endcase
      ok = v[i] && !stop;
      if (ni && iu >= 2) ok = 0;
      if ((nm && mu) || (nb && bu) || (na && au)) ok = 0;
      if (np && (pu || m_fpl > 0)) ok = 0;
      if ((solo || m_win > 0) && i > 0) ok = 0;
      if (ok) begin
        g[i] = 1; cnt++;
        if (ni) iu++;
        mu |= nm; bu |= nb; au |= na; pu |= np;
        if (w > wl) wl = w;
        if (f > fl) fl = f;
      end
      stop = !ok || brk || (m_win > 0);
    end
  endfunction

  task automatic step(input logic [3:0] v, input int c0, c1, c2, c3, input string tag);
    logic [3:0] eg;
    int ecnt, wl, fl;
    @(negedge clk);
    valid_i = v;
    class_i = {c3[4:0], c2[4:0], c1[4:0], c0[4:0]};
    #2;
    model(v, c0, c1, c2, c3, eg, ecnt, wl, fl);
    nvec++;
    if (grant_o !== eg || int'(issue_cnt_o) != ecnt) begin
      nfail++;
      $display("FAIL %s: grant=%b cnt=%0d expected grant=%b cnt=%0d (cls %0d %0d %0d %0d win=%0d fpl=%0d)",
               tag, grant_o, issue_cnt_o, eg, ecnt, c0, c1, c2, c3, m_win, m_fpl);
    end
    m_win = (wl > m_win - 1) ? wl : ((m_win > 0) ? m_win - 1 : 0);
    m_fpl = (fl > m_fpl - 1) ? fl : ((m_fpl > 0) ? m_fpl - 1 : 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R11: grants held low during reset
    valid_i = 4'hF;
    class_i = '0;
    repeat (3) begin
      @(negedge clk); #2;
      nvec++;
      if (grant_o !== 4'b0 || issue_cnt_o !== 3'd0) begin
        nfail++;
        $display("FAIL R11: grant=%b cnt=%0d expected grant=0000 cnt=0", grant_o, issue_cnt_o);
      end
    end
    @(negedge clk); rst_ni = 1'b1;

    step(4'hF, 1, 5, 0, 10, "R11");             // no leftover restriction: 4 issue
    step(4'hF, 0, 0, 0, 0, "R2");
    step(4'hF, 0, 1, 0, 0, "R2");
    step(4'hF, 1, 2, 0, 0, "R3");
    step(4'hF, 6, 1, 0, 0, "R3");
    step(4'hF, 13, 2, 0, 0, "R3");
    step(4'hF, 5, 0, 5, 0, "R4");
    step(4'hF, 7, 5, 0, 0, "R4");
    step(4'hF, 12, 5, 0, 0, "R4");
    step(4'hF, 10, 9, 0, 0, "R5");
    step(4'hF, 14, 10, 14, 0, "R5");
    step(4'hF, 12, 11, 0, 0, "R5");
    step(4'hF, 0, 8, 0, 0, "R6");
    step(4'hF, 8, 0, 0, 0, "R6");
    step(4'hF, 25, 0, 0, 0, "R10");
    step(4'hF, 0, 31, 0, 0, "R10");
    step(4'b1011, 0, 1, 0, 0, "R1");
    step(4'hF, 0, 0, 0, 1, "R1");
    step(4'b1110, 0, 0, 0, 0, "R1");

    step(4'hF, 0, 3, 0, 0, "R7");               // multiply ends group, opens window
    for (int k = 0; k < 6; k++) step(4'hF, 0, 0, 1, 5, "R8");
    step(4'hF, 4, 0, 0, 0, "R7");
    for (int k = 0; k < 75; k++) begin
      if (k == 20) step(4'hF, 3, 0, 0, 0, "R8");
      else         step(4'hF, 0, 1, 5, 10, "R8");
    end

    step(4'hF, 15, 0, 10, 0, "R9");
    for (int k = 0; k < 16; k++) step(4'hF, 0, 14, 0, 0, "R9");
    step(4'hF, 18, 0, 0, 0, "R9");
    for (int k = 0; k < 28; k++) step(4'hF, 16 + (k % 3), 0, 0, 0, "R9");
    step(4'hF, 17, 0, 0, 0, "R9");
    for (int k = 0; k < 20; k++) step(4'hF, 10, 14, 0, 0, "R9");

    for (int k = 0; k < 4000; k++) begin
      logic [3:0] v;
      v = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      step(v, $urandom_range(0, 23), $urandom_range(0, 23),
           $urandom_range(0, 23), $urandom_range(0, 23), "R1");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule